// File: doc/BRIEF.md
# MDIO Management Frame Master

This block sits on the MAC side of an Ethernet port and runs the two-wire serial management link to a PHY. It derives the management clock from the system clock and sends one read or write frame for each accepted host request. On a read it returns the 16-bit register value the PHY shifted back. The bidirectional data pad stays outside the block. The block provides a drive value, an output enable and a sampled input, so the pad cell can be placed at chip level.

The host raises `req_i` and presents the operation (`wr_i`), the PHY address, the register address, the write data and `no_pre_i`, which skips the preamble. A request is taken only while the block is idle. The block acknowledges with a one-cycle `ack_o` and then holds `busy_o` high until the frame has ended. The end is marked by a one-cycle `done_o`. On a read, `rdata_o` then holds the captured word.

The control FSM has five named states. `ST_IDLE` waits for a request. `ST_PRE` shifts the 32 preamble ones. `ST_HDR` shifts the start, opcode and the two address fields. `ST_TA` covers the two turnaround slots. `ST_DATA` covers the 16 data slots. The transitions are as follows:
- accept with preamble: `ST_IDLE`→`ST_PRE`
- accept with suppression: `ST_IDLE`→`ST_HDR`
- last preamble slot done: `ST_PRE`→`ST_HDR`
- last register-address slot done: `ST_HDR`→`ST_TA`
- second turnaround slot done: `ST_TA`→`ST_DATA`
- last data slot done: `ST_DATA`→`ST_IDLE`

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low and after its release, `mdc_o`=0, `mdio_oe_o`=0, `busy_o`=0, `done_o`=0, `ack_o`=0 and `rdata_o`=0.
- R2: A request is accepted at a rising `clk` edge where `req_i`=1 and `busy_o`=0. After that edge, `ack_o`=1 for exactly one cycle. `busy_o` is then high for exactly N·CLK_DIV cycles, where N is 64 with preamble and 32 without.
- R3: The frame is split into bit slots of CLK_DIV system cycles each. In each slot, `mdc_o` is low for the first CLK_DIV/2 cycles and high for the rest. `mdc_o` is low whenever the block is idle.
- R4: With `no_pre_i`=0, the 64 slots carry these bits in this order:
  - 32 ones
  - start bits 0 then 1
  - opcode: 1,0 for a read or 0,1 for a write
  - the PHY address, MSB first
  - the register address, MSB first
  - 2 turnaround slots
  - 16 data slots, MSB first
- R5: With `no_pre_i`=1, the frame has 32 slots and begins directly with the start bits. The rest of the frame is as in R4.
- R6: On a write (`wr_i`=1), the turnaround slots carry 1 then 0 and the data slots carry `wdata_i`. `mdio_oe_o` is 1 for the whole frame.
- R7: On a read (`wr_i`=0), `mdio_oe_o` is 1 through the last register-address slot. It is 0 for both turnaround slots and all 16 data slots.
- R8: On a read, `mdio_i` is sampled at the rising edge of `mdc_o` in each data slot. The first data slot gives the MSB.
- R9: `mdio_o` changes only at a slot boundary, while `mdc_o` is low.
- R10: `done_o` is high for one cycle, in the first cycle with `busy_o`=0 after a frame. `rdata_o` changes only together with `done_o` after a read. A write leaves it unchanged.
- R11: A request presented while `busy_o`=1 gets no `ack_o` and does not alter the frame in progress.
- R12: Taking `rst_n` low in the middle of a frame returns the block at once to the idle state of R1, keeping none of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, held until `ack_o` |
| wr_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| no_pre_i | input | 1 | 1 = skip the 32-slot preamble |
| ack_o | output | 1 | One-cycle acceptance pulse |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Last word read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive on the data pad |
| mdio_oe_o | output | 1 | Pad output enable |
| mdio_i | input | 1 | Value sampled from the data pad |

## Verification
The bench builds the block with CLK_DIV=6. With this value the high phase starts at a phase count of 3, which is not a power of two. Frames with and without preamble therefore stay short enough to cover every variant: reads, writes, back-to-back requests, requests held while busy, and a reset in mid-frame. A behavioural PHY counts rising `mdc_o` edges and answers reads. A cycle model built from the field order in R4 predicts every output on every clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int ADDR_BITS  = 5;
    localparam int DATA_BITS  = 16;
    localparam int TA_BITS    = 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // bit index (counting down) of the last register-address slot
    localparam int HDR_LAST_IDX  = DATA_BITS + TA_BITS;
    // bit index of the last turnaround slot
    localparam int TA_LAST_IDX   = DATA_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic end_stb
);

    localparam int HALF = CLK_DIV / 2;
    localparam int PW   = $clog2(CLK_DIV);
    localparam logic [PW-1:0] PH_RISE = PW'(HALF - 1);
    localparam logic [PW-1:0] PH_HIGH = PW'(HALF);
    localparam logic [PW-1:0] PH_END  = PW'(CLK_DIV - 1);

    logic [PW-1:0] ph_q;

    assign rise_stb = run && (ph_q == PH_RISE);
    assign end_stb  = run && (ph_q == PH_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
            mdc  <= 1'b0;
        end else if (!run) begin
            ph_q <= '0;
            mdc  <= 1'b0;
        end else begin
            ph_q <= end_stb ? '0 : ph_q + 1'b1;
            if (rise_stb)
                mdc <= 1'b1;
            else if (end_stb)
                mdc <= 1'b0;
        end
    end

    AST_MDC_RISE_MIDSLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> (ph_q == PH_HIGH)); // R3

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R3

endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
    import mdio_pkg::*;
(
    input  logic                  wr,
    input  logic [ADDR_BITS-1:0]  phy_addr,
    input  logic [ADDR_BITS-1:0]  reg_addr,
    input  logic [DATA_BITS-1:0]  wdata,
    output logic [FRAME_BITS-1:0] frame
);

    logic [1:0]           opcode;
    logic [TA_BITS-1:0]   ta_bits;
    logic [DATA_BITS-1:0] data_bits;

    always_comb begin
        opcode    = wr ? 2'b01 : 2'b10;
        ta_bits   = wr ? 2'b10 : 2'b00;
        data_bits = wr ? wdata : '0;
        frame     = {{PRE_BITS{1'b1}}, 2'b01, opcode, phy_addr, reg_addr,
                     ta_bits, data_bits};
    end

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic                 commit,
    input  logic                 mdio_in,
    output logic [DATA_BITS-1:0] rdata
);

    logic [DATA_BITS-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            rdata   <= '0;
        end else begin
            if (sample)
                shift_q <= {shift_q[DATA_BITS-2:0], mdio_in};
            if (commit)
                rdata <= shift_q;
        end
    end

    AST_RDATA_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> $past(commit)); // R10

    AST_NO_SAMPLE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !sample); // R8

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        wr_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    input  logic        no_pre_i,
    output logic        ack_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);

    localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(FRAME_BITS - PRE_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_PRE   = IDX_W'(FRAME_BITS - PRE_BITS);
    localparam logic [IDX_W-1:0] IDX_HDR   = IDX_W'(HDR_LAST_IDX);
    localparam logic [IDX_W-1:0] IDX_TA    = IDX_W'(TA_LAST_IDX);

    mdio_state_e           state_q, state_d;
    logic [IDX_W-1:0]      idx_q, idx_nx;
    logic [FRAME_BITS-1:0] frame_q, frame_new;
    logic                  wr_q;
    logic                  mdio_q, oe_q, ack_q, done_q;
    logic                  accept, run, rise_stb, end_stb, last_slot;
    logic                  cap_sample, cap_commit;

    assign run       = (state_q != ST_IDLE);
    assign accept    = req_i && !run;
    assign idx_nx    = idx_q - 1'b1;
    assign last_slot = end_stb && (idx_q == '0);

    mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mdc      (mdc_o),
        .rise_stb (rise_stb),
        .end_stb  (end_stb)
    );

    mdio_frame_build u_build (
        .wr       (wr_i),
        .phy_addr (phy_addr_i),
        .reg_addr (reg_addr_i),
        .wdata    (wdata_i),
        .frame    (frame_new)
    );

    assign cap_sample = rise_stb && (state_q == ST_DATA) && !wr_q;
    assign cap_commit = last_slot && (state_q == ST_DATA) && !wr_q;

    mdio_rx_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (cap_sample),
        .commit  (cap_commit),
        .mdio_in (mdio_i),
        .rdata   (rdata_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)                        state_d = no_pre_i ? ST_HDR : ST_PRE;
            ST_PRE:  if (end_stb && idx_q == IDX_PRE)   state_d = ST_HDR;
            ST_HDR:  if (end_stb && idx_q == IDX_HDR)   state_d = ST_TA;
            ST_TA:   if (end_stb && idx_q == IDX_TA)    state_d = ST_DATA;
            ST_DATA: if (last_slot)                     state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            frame_q <= '0;
            wr_q    <= 1'b0;
            mdio_q  <= 1'b1;
            oe_q    <= 1'b0;
            ack_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            ack_q  <= 1'b0;
            done_q <= 1'b0;
            if (accept) begin
                frame_q <= frame_new;
                wr_q    <= wr_i;
                idx_q   <= no_pre_i ? IDX_SHORT : IDX_FULL;
                mdio_q  <= no_pre_i ? frame_new[IDX_SHORT] : frame_new[IDX_FULL];
                oe_q    <= 1'b1;
                ack_q   <= 1'b1;
            end else if (run && end_stb) begin
                if (idx_q == '0) begin
                    mdio_q <= 1'b1;
                    oe_q   <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q  <= idx_nx;
                    mdio_q <= frame_q[idx_nx];
                    oe_q   <= wr_q || (idx_nx >= IDX_HDR);
                end
            end
        end
    end

    assign busy_o    = run;
    assign ack_o     = ack_q;
    assign done_o    = done_q;
    assign mdio_o    = mdio_q;
    assign mdio_oe_o = oe_q;

    AST_ACK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(!busy_o)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10

    AST_READ_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TA || state_q == ST_DATA) && !wr_q) |-> !mdio_oe_o); // R7

    AST_MDIO_MOVES_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc_o); // R9

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

    localparam int DIV  = 6;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        no_pre_i = 1'b0;
    logic        ack_o, busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;
    logic        mdio_i;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mdio_master #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .no_pre_i(no_pre_i), .ack_o(ack_o), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
        .mdio_i(mdio_i)
    );

    // ---------------- behavioural PHY ----------------
    logic [15:0] resp_word = 16'h0000;
    int  rises = 0;
    logic mdc_prev = 1'b0;
    bit  phy_nopre = 1'b0;
    int  dstart;
    assign dstart = (phy_nopre ? 0 : 32) + 16;
    assign mdio_i = (rises >= dstart && rises < dstart + 16) ?
                    resp_word[15 - (rises - dstart)] : 1'b1;

    always @(negedge clk) begin
        mdc_prev <= mdc_o;
        if (ack_o) begin
            rises     <= 0;
            phy_nopre <= no_pre_i;
        end else if (mdc_o && !mdc_prev) begin
            rises <= rises + 1;
        end
    end

    // ---------------- reference model ----------------
    bit          m_busy = 0, m_ack = 0, m_done = 0, m_wr = 0;
    int          m_k = 0, m_n = 64;
    logic [63:0] m_frame = '0;
    logic [15:0] m_rdata = '0, m_resp = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 0; m_ack <= 0; m_done <= 0; m_k <= 0; m_rdata <= '0;
        end else begin
            m_ack  <= 0;
            m_done <= 0;
            if (!m_busy) begin
                if (req_i) begin
                    m_busy  <= 1;
                    m_ack   <= 1;
                    m_k     <= 0;
                    m_wr    <= wr_i;
                    m_n     <= no_pre_i ? 32 : 64;
                    m_resp  <= resp_word;
                    m_frame <= {32'hFFFF_FFFF, 2'b01, (wr_i ? 2'b01 : 2'b10),
                                phy_addr_i, reg_addr_i, (wr_i ? 2'b10 : 2'b00),
                                (wr_i ? wdata_i : 16'h0)};
                end
            end else if (m_k == m_n * DIV - 1) begin
                m_busy <= 0;
                m_done <= 1;
                if (!m_wr) m_rdata <= m_resp;
            end else begin
                m_k <= m_k + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int  s, bidx;
            bit  e_mdc, e_oe, e_mdio;
            s      = m_k / DIV;
            bidx   = m_n - 1 - s;
            e_mdc  = m_busy && ((m_k % DIV) >= HALF);
            e_oe   = m_busy && (m_wr || bidx >= 18);
            e_mdio = m_frame[bidx];
            chk(ack_o == m_ack, "R2 R11 ack", ack_o, m_ack);
            chk(busy_o == m_busy, "R2 busy", busy_o, m_busy);
            chk(done_o == m_done, "R10 done", done_o, m_done);
            chk(mdc_o == e_mdc, "R3 mdc", mdc_o, e_mdc);
            chk(mdio_oe_o == e_oe, "R6 R7 oe", mdio_oe_o, e_oe);
            if (e_oe)  // R4 R5 R6 R9 field order and slot timing
                chk(mdio_o == e_mdio, "R4 R5 R6 R9 mdio", mdio_o, e_mdio);
            chk(rdata_o == m_rdata, "R8 R10 rdata", rdata_o, m_rdata);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_txn(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input bit np, input logic [15:0] resp,
                           input bit poke_busy);
        @(negedge clk);
        wr_i = wr; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
        no_pre_i = np; resp_word = resp; req_i = 1'b1;
        do @(negedge clk); while (!ack_o);
        req_i = 1'b0;
        if (poke_busy) begin
            // R11: a request during the frame must be ignored
            @(negedge clk);
            wr_i = ~wr; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
            no_pre_i = ~np; req_i = 1'b1;
            repeat (40) @(negedge clk);
            req_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(mdc_o == 0 && mdio_oe_o == 0 && busy_o == 0 && done_o == 0,
            "R1 idle in reset", {mdc_o, mdio_oe_o, busy_o, done_o}, 0);
        chk(rdata_o == 0, "R1 rdata in reset", rdata_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_o == 0 && busy_o == 0, "R1 after release", {ack_o, busy_o}, 0);

        run_txn(1, 5'h13, 5'h0A, 16'hA5C3, 0, 16'h0000, 0);   // R4 R6 write
        run_txn(0, 5'h01, 5'h1F, 16'h0000, 0, 16'hBEEF, 0);   // R7 R8 read
        run_txn(1, 5'h1F, 5'h00, 16'h0001, 1, 16'h0000, 0);   // R5 write short
        chk(rdata_o == 16'hBEEF, "R10 rdata kept after write", rdata_o, 16'hBEEF);
        run_txn(0, 5'h0C, 5'h15, 16'h0000, 1, 16'h8001, 0);   // R5 R8 read short
        run_txn(0, 5'h1A, 5'h03, 16'h0000, 0, 16'h5A3C, 1);   // R11 busy request
        run_txn(1, 5'h00, 5'h1F, 16'hFFFF, 1, 16'h0000, 1);   // R11 on write
        run_txn(1, 5'h15, 5'h0A, 16'h6E2D, 0, 16'h0000, 0);   // back to back

        // R12 reset in the middle of a read
        @(negedge clk);
        wr_i = 0; phy_addr_i = 5'h07; reg_addr_i = 5'h11; no_pre_i = 0;
        resp_word = 16'h1234; req_i = 1'b1;
        do @(negedge clk); while (!ack_o);
        req_i = 1'b0;
        repeat (250) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(busy_o == 0 && mdc_o == 0 && mdio_oe_o == 0, "R12 abort to idle",
            {busy_o, mdc_o, mdio_oe_o}, 0);
        chk(rdata_o == 0, "R12 rdata cleared", rdata_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_txn(0, 5'h07, 5'h11, 16'h0000, 0, 16'hC0DE, 0);   // R8 after reset
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule